// File: doc/BRIEF.md
# Dual-Issue Pair Legality and Steering Logic

This block sits in a two-wide, in-order issue stage. Each cycle it looks at the two oldest decoded instructions, given in program order with a class code and a valid bit each. It decides whether both may leave together, only the older one, or none. It also names the issue slot and the execution unit that each accepted instruction goes to. The logic is purely combinational, so the answer is ready in the same cycle as the inputs.

The two slots are not alike. The memory slot feeds a single adder/address unit. The float slot feeds one of six units: an integer adder, a branch unit, an integer multiply/divide unit, an FP adder, an FP multiplier or an FP divide/sqrt unit. Only one of these six may start in a given cycle. Plain integer work may go to either slot. The steering follows the partner instruction, and when the choice is free it follows the `ALU_PREF_MEM` option. Data hazards between the pair are detected elsewhere and arrive on a single flag, which forbids pairing.

Top module: `dual_issue_pair`

## Requirements
- R1: When `i0_valid` is 0, `issue_count` is 0, both unit outputs are 0 (none), and both slot outputs are 0, whatever the other inputs are.
- R2: When `i0_valid` is 1 and `i1_valid` is 0, `issue_count` is 1.
- R3: Class codes: 0 integer ALU (arith, shift, compare, clz, constant, cond-move, nop, trap, register-file transfer), 1 load, 2 store, 3 integer multiply, 4 integer divide, 5 branch/jump/call, 6 FP add/compare/convert/move, 7 FP multiply, 8 FP divide/sqrt, 9 unknown/multi. Loads and stores need the memory slot, so two of them (codes 1 and 2 in any mix) never pair.
- R4: Classes 3 to 8 need the float slot, so no two of them pair.
- R5: Unit codes: 0 none, 1 memory adder/address, 2 float-slot integer adder, 3 branch, 4 integer multiply/divide, 5 FP add, 6 FP multiply, 7 FP divide/sqrt, 8 whole-group (both slots). An ALU instruction paired with a memory-slot class is sent to unit 2. An ALU instruction paired with a float-slot class is sent to unit 1.
- R6: A branch in position 0 always issues alone. A branch in position 1 may pair with an older ALU, load or store instruction.
- R7: Class 9, and any code above 9, takes unit 8 and issues alone in either position. When `i1` has such a code, only `i0` issues.
- R8: When `i1_dep` is 1, at most one instruction issues.
- R9: An instruction that issues alone gets the unit of its class: loads and stores unit 1, multiply/divide unit 4, branch unit 3, and FP classes units 5, 6 and 7. ALU gets unit 1 when `ALU_PREF_MEM` is 1 and unit 2 otherwise.
- R10: When two instructions issue, their slots differ, exactly one of them gets unit 1, and slot 0 is the memory slot.
- R11: When `issue_count` is below 2, `i1_unit` is 0 and `i1_slot` is 0.
- R12: Two ALU instructions pair. The older one takes the preferred adder, and the younger one takes the other adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i0_valid | input | 1 | Older instruction present |
| i0_class | input | CLS_W | Older instruction class code |
| i1_valid | input | 1 | Younger instruction present |
| i1_class | input | CLS_W | Younger instruction class code |
| i1_dep | input | 1 | Younger reads a result of the older |
| issue_count | output | 2 | Instructions leaving this cycle (0, 1 or 2) |
| i0_unit | output | UNIT_W | Unit code for the older instruction |
| i0_slot | output | 1 | Slot for the older instruction (0 memory, 1 float) |
| i1_unit | output | UNIT_W | Unit code for the younger instruction |
| i1_slot | output | 1 | Slot for the younger instruction |

## Verification
The hardest case to reach is a flexible ALU instruction whose adder depends on the class of its partner. It must flip from the memory adder to the float-slot adder only when a valid, independent, pairable partner needs the memory slot. The stimulus covers this by sweeping every pair of the sixteen class codes under all eight combinations of the two valid bits and the dependency flag. The same sweep reaches the rarer codes above 9 and the branch-first and dependent-pair cases that suppress the flip.

// File: rtl/dis_pkg.sv
package dis_pkg;

   localparam int CODE_W = 4;

   localparam logic [CODE_W-1:0] CL_ALU    = 4'd0;
   localparam logic [CODE_W-1:0] CL_LOAD   = 4'd1;
   localparam logic [CODE_W-1:0] CL_STORE  = 4'd2;
   localparam logic [CODE_W-1:0] CL_IMUL   = 4'd3;
   localparam logic [CODE_W-1:0] CL_IDIV   = 4'd4;
   localparam logic [CODE_W-1:0] CL_BRANCH = 4'd5;
   localparam logic [CODE_W-1:0] CL_FADD   = 4'd6;
   localparam logic [CODE_W-1:0] CL_FMUL   = 4'd7;
   localparam logic [CODE_W-1:0] CL_FDIV   = 4'd8;
   localparam logic [CODE_W-1:0] CL_SOLO   = 4'd9;

   localparam logic [CODE_W-1:0] UN_NONE   = 4'd0;
   localparam logic [CODE_W-1:0] UN_MEM    = 4'd1;
   localparam logic [CODE_W-1:0] UN_FINT   = 4'd2;
   localparam logic [CODE_W-1:0] UN_BR     = 4'd3;
   localparam logic [CODE_W-1:0] UN_MULDIV = 4'd4;
   localparam logic [CODE_W-1:0] UN_FPADD  = 4'd5;
   localparam logic [CODE_W-1:0] UN_FPMUL  = 4'd6;
   localparam logic [CODE_W-1:0] UN_FPDIV  = 4'd7;
   localparam logic [CODE_W-1:0] UN_GROUP  = 4'd8;

   typedef enum logic [1:0] {
      NEED_MEM = 2'd0,
      NEED_FLT = 2'd1,
      NEED_ANY = 2'd2
   } need_e;

   typedef struct packed {
      need_e             need;
      logic              is_br;
      logic              is_solo;
      logic [CODE_W-1:0] flt_unit;
   } lane_info_t;

endpackage

// File: rtl/dis_classify.sv
module dis_classify
   import dis_pkg::*;
#(
   parameter int CLS_W = 4
) (
   input  logic [CLS_W-1:0] cls,
   output lane_info_t       info
);
   localparam int HI_W = CLS_W - CODE_W;

   logic              hi_set;
   logic [CODE_W-1:0] lo;

   assign lo = cls[CODE_W-1:0];

   generate
      if (HI_W > 0) begin : g_wide
         assign hi_set = |cls[CLS_W-1:CODE_W];
      end else begin : g_narrow
         assign hi_set = 1'b0;
      end
   endgenerate

   always_comb begin
      info.need     = NEED_FLT;
      info.is_br    = 1'b0;
      info.is_solo  = 1'b0;
      info.flt_unit = UN_GROUP;
      if (hi_set) begin
         info.is_solo = 1'b1;
      end else begin
         case (lo)
            CL_ALU:    begin info.need = NEED_ANY; info.flt_unit = UN_FINT;   end
            CL_LOAD,
            CL_STORE:  begin info.need = NEED_MEM; info.flt_unit = UN_NONE;   end
            CL_IMUL,
            CL_IDIV:   info.flt_unit = UN_MULDIV;
            CL_BRANCH: begin info.is_br = 1'b1;    info.flt_unit = UN_BR;     end
            CL_FADD:   info.flt_unit = UN_FPADD;
            CL_FMUL:   info.flt_unit = UN_FPMUL;
            CL_FDIV:   info.flt_unit = UN_FPDIV;
            default:   info.is_solo = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/dis_pair_rules.sv
module dis_pair_rules
   import dis_pkg::*;
#(
   parameter bit ALU_PREF_MEM = 1'b1
) (
   input  logic       v0,
   input  logic       v1,
   input  logic       dep,
   input  lane_info_t l0,
   input  lane_info_t l1,
   output logic [1:0] count,
   output logic       flt0,
   output logic       flt1
);
   logic both_mem, both_flt, group_cut, can_pair;
   logic any0_to_flt_alone, any0_to_flt_pair;

   assign both_mem  = (l0.need == NEED_MEM) && (l1.need == NEED_MEM);
   assign both_flt  = (l0.need == NEED_FLT) && (l1.need == NEED_FLT);
   assign group_cut = l0.is_br || l0.is_solo || l1.is_solo;
   assign can_pair  = v0 && v1 && !dep && !group_cut && !both_mem && !both_flt;

   generate
      if (ALU_PREF_MEM) begin : g_pref_mem
         assign any0_to_flt_alone = 1'b0;
         assign any0_to_flt_pair  = (l1.need == NEED_MEM);
      end else begin : g_pref_flt
         assign any0_to_flt_alone = 1'b1;
         assign any0_to_flt_pair  = (l1.need != NEED_FLT);
      end
   endgenerate

   always_comb begin
      count = 2'd0;
      flt0  = 1'b0;
      flt1  = 1'b0;
      if (v0) begin
         if (can_pair) begin
            count = 2'd2;
            flt0  = (l0.need == NEED_FLT) ||
                    ((l0.need == NEED_ANY) && any0_to_flt_pair);
            flt1  = !flt0;
         end else begin
            count = 2'd1;
            flt0  = (l0.need == NEED_FLT) ||
                    ((l0.need == NEED_ANY) && any0_to_flt_alone);
         end
      end
   end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import dis_pkg::*;
#(
   parameter int CLS_W        = 4,
   parameter int UNIT_W       = 4,
   parameter bit ALU_PREF_MEM = 1'b1
) (
   input  logic              i0_valid,
   input  logic [CLS_W-1:0]  i0_class,
   input  logic              i1_valid,
   input  logic [CLS_W-1:0]  i1_class,
   input  logic              i1_dep,
   output logic [1:0]        issue_count,
   output logic [UNIT_W-1:0] i0_unit,
   output logic              i0_slot,
   output logic [UNIT_W-1:0] i1_unit,
   output logic              i1_slot
);
   localparam int LANES = 2;
   localparam int PAD_W = UNIT_W - CODE_W;

   generate
      if (CLS_W < CODE_W) begin : g_bad_cls
         $error("dual_issue_pair: CLS_W must be at least %0d", CODE_W);
      end
      if (UNIT_W < CODE_W) begin : g_bad_unit
         $error("dual_issue_pair: UNIT_W must be at least %0d", CODE_W);
      end
   endgenerate

   logic [CLS_W-1:0]  cls_a   [LANES];
   lane_info_t        info_a  [LANES];
   logic              go_a    [LANES];
   logic              flt_a   [LANES];
   logic [CODE_W-1:0] code_a  [LANES];
   logic [1:0]        cnt;
   logic              flt0, flt1;

   assign cls_a[0] = i0_class;
   assign cls_a[1] = i1_class;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dis_classify #(.CLS_W(CLS_W)) u_cls (
            .cls  (cls_a[g]),
            .info (info_a[g])
         );
         always_comb begin
            if (!go_a[g])                code_a[g] = UN_NONE;
            else if (info_a[g].is_solo)  code_a[g] = UN_GROUP;
            else if (flt_a[g])           code_a[g] = info_a[g].flt_unit;
            else                         code_a[g] = UN_MEM;
         end
      end
   endgenerate

   dis_pair_rules #(.ALU_PREF_MEM(ALU_PREF_MEM)) u_rules (
      .v0    (i0_valid),
      .v1    (i1_valid),
      .dep   (i1_dep),
      .l0    (info_a[0]),
      .l1    (info_a[1]),
      .count (cnt),
      .flt0  (flt0),
      .flt1  (flt1)
   );

   assign go_a[0]  = (cnt != 2'd0);
   assign go_a[1]  = (cnt == 2'd2);
   assign flt_a[0] = flt0 && !info_a[0].is_solo;
   assign flt_a[1] = flt1;

   assign issue_count = cnt;
   assign i0_slot     = go_a[0] && flt_a[0];
   assign i1_slot     = go_a[1] && flt_a[1];

   generate
      if (PAD_W > 0) begin : g_pad
         assign i0_unit = {{PAD_W{1'b0}}, code_a[0]};
         assign i1_unit = {{PAD_W{1'b0}}, code_a[1]};
      end else begin : g_exact
         assign i0_unit = code_a[0];
         assign i1_unit = code_a[1];
      end
   endgenerate
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check #(
   parameter int CLS_W  = 4,
   parameter int UNIT_W = 4
) (
   input logic              i0_valid,
   input logic [CLS_W-1:0]  i0_class,
   input logic              i1_valid,
   input logic              i1_dep,
   input logic [1:0]        issue_count,
   input logic [UNIT_W-1:0] i0_unit,
   input logic              i0_slot,
   input logic [UNIT_W-1:0] i1_unit,
   input logic              i1_slot
);
   always_comb begin
      if (!i0_valid)
         AST_IDLE_NOTHING: assert (issue_count == 2'd0 && i0_unit == '0 && i1_unit == '0); // R1
      if (i0_valid && !i1_valid)
         AST_LONE_ISSUES_ONE: assert (issue_count == 2'd1); // R2
      if (i0_valid && i1_dep)
         AST_DEP_BLOCKS_PAIR: assert (issue_count == 2'd1); // R8
      if (i0_valid && i0_class == CLS_W'(5))
         AST_BRANCH_ENDS_GROUP: assert (issue_count == 2'd1); // R6
      if (issue_count == 2'd2)
         AST_PAIR_SPLITS_PIPES: assert (i0_slot != i1_slot &&
                                        ((i0_unit == UNIT_W'(1)) != (i1_unit == UNIT_W'(1)))); // R10
      if (issue_count == 2'd2)
         AST_PAIR_NO_GROUP_UNIT: assert (i0_unit != UNIT_W'(8) && i1_unit != UNIT_W'(8)); // R7
      if (issue_count != 2'd2)
         AST_TAIL_IDLE: assert (i1_unit == '0 && !i1_slot); // R11
      AST_COUNT_RANGE: assert (issue_count != 2'd3); // R1
   end
endmodule

bind dual_issue_pair dual_issue_pair_check #(.CLS_W(CLS_W), .UNIT_W(UNIT_W)) u_check (
   .i0_valid    (i0_valid),
   .i0_class    (i0_class),
   .i1_valid    (i1_valid),
   .i1_dep      (i1_dep),
   .issue_count (issue_count),
   .i0_unit     (i0_unit),
   .i0_slot     (i0_slot),
   .i1_unit     (i1_unit),
   .i1_slot     (i1_slot)
);

// File: tb/dual_issue_pair_bench.sv
module dual_issue_pair_bench;
   localparam int CW = 4;
   localparam int UW = 4;
   localparam bit PREF_MEM = 1'b1;

   logic          clk = 1'b0;
   logic          v0, v1, dep;
   logic [CW-1:0] c0, c1;
   logic [1:0]    cnt;
   logic [UW-1:0] u0, u1;
   logic          s0, s1;
   int            checks = 0;
   int            fails = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   dual_issue_pair #(.CLS_W(CW), .UNIT_W(UW), .ALU_PREF_MEM(PREF_MEM)) u_dual_issue_pair (
      .i0_valid(v0), .i0_class(c0), .i1_valid(v1), .i1_class(c1), .i1_dep(dep),
      .issue_count(cnt), .i0_unit(u0), .i0_slot(s0), .i1_unit(u1), .i1_slot(s1)
   );

   // pipe letter: M memory only, F float only, A either, S whole group
   function automatic byte pipe_of(int c);
      if (c == 0) return "A";
      if (c == 1 || c == 2) return "M";
      if (c >= 3 && c <= 8) return "F";
      return "S";
   endfunction

   function automatic int fl_unit(int c);
      case (c)
         0: return 2;  3, 4: return 4;  5: return 3;
         6: return 5;  7: return 6;     8: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic int alone_unit(int c);
      byte p = pipe_of(c);
      if (p == "S") return 8;
      if (p == "M") return 1;
      if (p == "A") return PREF_MEM ? 1 : 2;
      return fl_unit(c);
   endfunction

   task automatic chk(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d (v0=%0b c0=%0d v1=%0b c1=%0d dep=%0b)",
                  tag, what, act, exp, v0, c0, v1, c1, dep);
      end
   endtask

   task automatic apply(bit a_v, int a_c, bit b_v, int b_c, bit d);
      @(negedge clk);
      v0 = a_v; c0 = CW'(a_c); v1 = b_v; c1 = CW'(b_c); dep = d;
      #2;
   endtask

   task automatic expect_all(string tag, int e_cnt, int e_u0, int e_u1);
      chk(tag, int'(cnt), e_cnt, "count");
      chk(tag, int'(u0), e_u0, "unit0");
      chk(tag, int'(u1), e_u1, "unit1");
   endtask

   function automatic string tag_of(bit a_v, int a, bit b_v, int b, bit d);
      if (!a_v) return "R1";
      if (pipe_of(a) == "S" || (b_v && pipe_of(b) == "S")) return "R7";
      if (a == 5) return "R6";
      if (d) return "R8";
      if (!b_v) return "R2";
      if (pipe_of(a) == "M" && pipe_of(b) == "M") return "R3";
      if (pipe_of(a) == "F" && pipe_of(b) == "F") return "R4";
      return "R10";
   endfunction

   initial begin
      v0 = 0; v1 = 0; dep = 0; c0 = '0; c1 = '0;
      #3;
      // reset state: nothing valid
      chk("R1", int'(cnt), 0, "count at start");
      chk("R1", int'(u0), 0, "unit0 at start");
      chk("R11", int'(s1), 0, "slot1 at start");

      // directed corner cases
      apply(1, 1, 1, 2, 0); expect_all("R3", 1, 1, 0);
      apply(1, 6, 1, 3, 0); expect_all("R4", 1, 5, 0);
      apply(1, 0, 1, 1, 0); expect_all("R5", 2, 2, 1);
      apply(1, 0, 1, 7, 0); expect_all("R5", 2, 1, 6);
      apply(1, 5, 1, 0, 0); expect_all("R6", 1, 3, 0);
      apply(1, 2, 1, 5, 0); expect_all("R6", 2, 1, 3);
      apply(1, 9, 1, 0, 0); expect_all("R7", 1, 8, 0);
      apply(1, 0, 1, 14, 0); expect_all("R7", 1, 1, 0);
      apply(1, 0, 1, 1, 1); expect_all("R8", 1, 1, 0);
      apply(1, 8, 0, 1, 0); expect_all("R9", 1, 7, 0);
      apply(1, 0, 1, 0, 0); expect_all("R12", 2, 1, 2);
      chk("R10", int'(s0), 0, "slot0 for memory lane");
      chk("R10", int'(s1), 1, "slot1 for float lane");
      apply(0, 3, 1, 0, 0); expect_all("R1", 0, 0, 0);

      // full sweep of every class pair and control combination
      for (int m = 0; m < 8; m++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               bit ev0 = m[0], ev1 = m[1], ed = m[2];
               byte pa = pipe_of(a), pb = pipe_of(b);
               int e_cnt, e_u0, e_u1;
               bit pairable;
               pairable = ev0 && ev1 && !ed && pa != "S" && pb != "S" && a != 5 &&
                          !(pa == "M" && pb == "M") && !(pa == "F" && pb == "F");
               if (!ev0) begin
                  e_cnt = 0; e_u0 = 0; e_u1 = 0;
               end else if (!pairable) begin
                  e_cnt = 1; e_u0 = alone_unit(a); e_u1 = 0;
               end else begin
                  e_cnt = 2;
                  if (pa == "M")      begin e_u0 = 1; e_u1 = fl_unit(b); end
                  else if (pa == "F") begin e_u0 = fl_unit(a); e_u1 = 1; end
                  else if (pb == "M") begin e_u0 = 2; e_u1 = 1; end
                  else if (pb == "F") begin e_u0 = 1; e_u1 = fl_unit(b); end
                  else if (PREF_MEM)  begin e_u0 = 1; e_u1 = 2; end
                  else                begin e_u0 = 2; e_u1 = 1; end
               end
               apply(ev0, a, ev1, b, ed);
               expect_all(tag_of(ev0, a, ev1, b, ed), e_cnt, e_u0, e_u1);
               chk("R10", int'(s0), (e_cnt != 0 && e_u0 != 1 && e_u0 != 8) ? 1 : 0, "slot0");
               chk("R11", int'(s1), (e_cnt == 2 && e_u1 != 1) ? 1 : 0, "slot1");
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule